// File: doc/BRIEF.md
# Decimal Injection Pre-correction Stage

This stage sits between decimal operand alignment and a binary-style carry-propagate network. It takes two already aligned BCD operands and rewrites them so that an ordinary binary carry network, followed by a simple per-digit fix-up, yields a correct decimal sum or difference. It also pre-loads a rounding constant, so that the rounding step downstream only has to truncate.

The stage first works out whether the operation is an effective add or an effective subtract. It does this from the two operand signs and the requested operation. It then places the operands in a 19-digit frame: a 16-digit significand plus three low positions (guard, round and a sticky digit). The placement depends on the effective operation.

For an effective add, every digit of operand A is biased by 6. For an effective subtract, every digit of operand B is inverted. Last, a rounding-mode-dependent digit pair is written into the round and sticky positions of A. The stage is a single registered pipeline step: results appear one clock after a valid input and stay unchanged until the next valid input.

Top module: `dec_inj_precorr`

## Requirements
- R1: `effSub` equals `signA ^ signB ^ opSub` (opSub 0 = add, 1 = subtract) for the input accepted with `inValid` high. It appears with `outValid` high on the clock edge after acceptance. `outValid` is low after any cycle in which `inValid` was low.
- R2: For an effective add, A is placed as follows: digit 18 is 0, digits 17..2 hold `sigA` digits 15..0, and digits 1 and 0 hold the injected round and sticky values. Every digit of that frame then has 6 added, so digit 18 of `corrA` reads 6.
- R3: For an effective add, B is placed as follows: digit 18 is 0, and digits 17..1 hold `alnB` digits 17..1. Digit 0 is 1 if `alnB` digit 0 is nonzero or `stickyIn` is set, and 0 otherwise. No bias is applied to B.
- R4: For an effective subtract, A is placed as follows: digits 18..3 hold `sigA` digits 15..0, the guard digit 2 is 0, and digits 1 and 0 hold the injected values. No bias is applied to A.
- R5: For an effective subtract, B is placed as follows: digits 18..1 hold 15 minus `alnB` digits 17..0, and digit 0 holds 15 minus `stickyIn`.
- R6: The injected (round, sticky) pair depends on the `rndMode` code. Code 0 (toward zero) gives (0,0). Code 1 (ties away from zero) gives (5,0). Code 2 (ties to even) gives (5,0). Code 3 (ties toward zero) gives (4,9). Code 4 (away from zero) gives (9,9).
- R7: For the directed modes, `resSign` selects the pair (`resSign` 1 = negative result). Code 5 (toward plus infinity) gives (9,9) for a positive result and (0,0) for a negative one. Code 6 (toward minus infinity) gives (9,9) for a negative result and (0,0) for a positive one.
- R8: The unused code 7 injects (0,0), the same as toward zero.
- R9: While `rstN` is low, `outValid`, `effSub`, `corrA` and `corrB` are 0. While `inValid` is low, `corrA`, `corrB` and `effSub` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand set present this cycle |
| signA | input | 1 | Sign of operand A |
| signB | input | 1 | Sign of operand B |
| opSub | input | 1 | Requested operation, 1 = subtract |
| rndMode | input | 3 | Rounding mode code |
| resSign | input | 1 | Predicted result sign for directed modes, 1 = negative |
| sigA | input | 64 | Operand A significand, 16 BCD digits |
| alnB | input | 72 | Right-aligned operand B, 18 BCD digits |
| stickyIn | input | 1 | OR of digits shifted out of B |
| corrA | output | 76 | Corrected operand A, 19 digits |
| corrB | output | 76 | Corrected operand B, 19 digits |
| effSub | output | 1 | Effective subtract flag |
| outValid | output | 1 | Outputs updated this cycle |

## Verification
A wrong effective-operation decode selects the wrong placement. The top digit of A then reads 0 instead of 6, or B is inverted when it should not be, and this shows on the first result after the bad input, one cycle after acceptance. A wrong entry in the injection table shows only in the two lowest digits of `corrA`. It is caught only when the faulty mode is used, and for the directed modes only with the matching result sign, so every code is driven with both signs and both effective operations. A faulty load enable shows as outputs that drift during idle cycles. Idle inputs are therefore toggled, and the outputs are compared against the last accepted result.

// File: rtl/dec_inj_pkg.sv
package dec_inj_pkg;

  localparam int DIG_W = 4;

  typedef enum logic [2:0] {
    RM_TOWARD_ZERO = 3'd0,
    RM_TIES_AWAY   = 3'd1,
    RM_TIES_EVEN   = 3'd2,
    RM_TIES_ZERO   = 3'd3,
    RM_AWAY        = 3'd4,
    RM_UP          = 3'd5,
    RM_DOWN        = 3'd6,
    RM_SPARE       = 3'd7
  } rndMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             load;
    logic             effSub;
    logic [DIG_W-1:0] injRound;
    logic [DIG_W-1:0] injSticky;
  } ctrlStrobe_t;

endpackage

// File: rtl/dec_inj_ctrl.sv
module dec_inj_ctrl
  import dec_inj_pkg::*;
(
  input  logic        inValid,
  input  logic        signA,
  input  logic        signB,
  input  logic        opSub,
  input  logic [2:0]  rndMode,
  input  logic        resSign,
  output ctrlStrobe_t strobe
);

  localparam logic [DIG_W-1:0] NINE = DIG_W'(9);
  localparam logic [DIG_W-1:0] FIVE = DIG_W'(5);
  localparam logic [DIG_W-1:0] FOUR = DIG_W'(4);

  always_comb begin
    strobe.load      = inValid;
    strobe.effSub    = signA ^ signB ^ opSub;
    strobe.injRound  = '0;
    strobe.injSticky = '0;
    case (rndMode_e'(rndMode))
      RM_TIES_AWAY, RM_TIES_EVEN: begin
        strobe.injRound = FIVE;
      end
      RM_TIES_ZERO: begin
        strobe.injRound  = FOUR;
        strobe.injSticky = NINE;
      end
      RM_AWAY: begin
        strobe.injRound  = NINE;
        strobe.injSticky = NINE;
      end
      RM_UP: begin
        if (!resSign) begin
          strobe.injRound  = NINE;
          strobe.injSticky = NINE;
        end
      end
      RM_DOWN: begin
        if (resSign) begin
          strobe.injRound  = NINE;
          strobe.injSticky = NINE;
        end
      end
      default: begin
        strobe.injRound  = '0;
        strobe.injSticky = '0;
      end
    endcase
  end

endmodule

// File: rtl/dec_inj_datapath.sv
module dec_inj_datapath
  import dec_inj_pkg::*;
#(
  parameter int SIG_DIGITS = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  input  logic [SIG_DIGITS*DIG_W-1:0]     sigA,
  input  logic [(SIG_DIGITS+2)*DIG_W-1:0] alnB,
  input  logic                           stickyIn,
  output logic [(SIG_DIGITS+3)*DIG_W-1:0] corrA,
  output logic [(SIG_DIGITS+3)*DIG_W-1:0] corrB,
  output logic                           effSub,
  output logic                           outValid
);

  localparam int ALN_DIGITS = SIG_DIGITS + 2;
  localparam int TOT_DIGITS = SIG_DIGITS + 3;
  localparam int TOT_W      = TOT_DIGITS * DIG_W;
  localparam logic [DIG_W-1:0] BIAS = DIG_W'(6);

  logic [TOT_W-1:0] placedA;
  logic [TOT_W-1:0] placedB;
  logic [TOT_W-1:0] nextA;

  // Operand placement by effective operation, then injection.
  always_comb begin
    placedA = '0;
    placedB = '0;
    if (strobe.effSub) begin
      for (int i = 0; i < SIG_DIGITS; i++)
        placedA[(i+3)*DIG_W +: DIG_W] = sigA[i*DIG_W +: DIG_W];
      for (int j = 0; j < ALN_DIGITS; j++)
        placedB[(j+1)*DIG_W +: DIG_W] = ~alnB[j*DIG_W +: DIG_W];
      placedB[DIG_W-1:0] = {{(DIG_W-1){1'b1}}, ~stickyIn};
    end else begin
      for (int i = 0; i < SIG_DIGITS; i++)
        placedA[(i+2)*DIG_W +: DIG_W] = sigA[i*DIG_W +: DIG_W];
      for (int j = 1; j < ALN_DIGITS; j++)
        placedB[j*DIG_W +: DIG_W] = alnB[j*DIG_W +: DIG_W];
      placedB[DIG_W-1:0] = {{(DIG_W-1){1'b0}}, (|alnB[DIG_W-1:0]) | stickyIn};
    end
    placedA[2*DIG_W-1:DIG_W] = strobe.injRound;
    placedA[DIG_W-1:0]       = strobe.injSticky;
  end

  // Per-digit bias for effective add.
  for (genvar g = 0; g < TOT_DIGITS; g++) begin : gBias
    assign nextA[g*DIG_W +: DIG_W] = strobe.effSub ? placedA[g*DIG_W +: DIG_W]
                                                   : placedA[g*DIG_W +: DIG_W] + BIAS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      corrA    <= '0;
      corrB    <= '0;
      effSub   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        corrA  <= nextA;
        corrB  <= placedB;
        effSub <= strobe.effSub;
      end
    end
  end

endmodule

// File: rtl/dec_inj_precorr.sv
module dec_inj_precorr
  import dec_inj_pkg::*;
#(
  parameter int SIG_DIGITS = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic                           signA,
  input  logic                           signB,
  input  logic                           opSub,
  input  logic [2:0]                     rndMode,
  input  logic                           resSign,
  input  logic [SIG_DIGITS*4-1:0]        sigA,
  input  logic [(SIG_DIGITS+2)*4-1:0]    alnB,
  input  logic                           stickyIn,
  output logic [(SIG_DIGITS+3)*4-1:0]    corrA,
  output logic [(SIG_DIGITS+3)*4-1:0]    corrB,
  output logic                           effSub,
  output logic                           outValid
);

  ctrlStrobe_t strobe;

  dec_inj_ctrl uCtrl (
    .inValid (inValid),
    .signA   (signA),
    .signB   (signB),
    .opSub   (opSub),
    .rndMode (rndMode),
    .resSign (resSign),
    .strobe  (strobe)
  );

  dec_inj_datapath #(.SIG_DIGITS(SIG_DIGITS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sigA     (sigA),
    .alnB     (alnB),
    .stickyIn (stickyIn),
    .corrA    (corrA),
    .corrB    (corrB),
    .effSub   (effSub),
    .outValid (outValid)
  );

endmodule

// File: rtl/dec_inj_precorr_chk.sv
module dec_inj_precorr_chk #(
  parameter int SIG_DIGITS = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        inValid,
  input logic                        signA,
  input logic                        signB,
  input logic                        opSub,
  input logic [2:0]                  rndMode,
  input logic [(SIG_DIGITS+2)*4-1:0] alnB,
  input logic [(SIG_DIGITS+3)*4-1:0] corrA,
  input logic [(SIG_DIGITS+3)*4-1:0] corrB,
  input logic                        effSub,
  input logic                        outValid
);

  localparam int TOT_W = (SIG_DIGITS + 3) * 4;
  localparam int ALN_W = (SIG_DIGITS + 2) * 4;

  AST_EFF_OP: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> effSub == ($past(signA) ^ $past(signB) ^ $past(opSub))); // R1
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_ADD_TOP_A: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !effSub) |-> corrA[TOT_W-1 -: 4] == 4'd6); // R2
  AST_ADD_TOP_B: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !effSub) |-> corrB[TOT_W-1 -: 4] == 4'd0); // R3
  AST_SUB_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && effSub) |-> corrA[11:8] == 4'd0); // R4
  AST_SUB_INV_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (signA ^ signB ^ opSub)) |=>
      corrB[TOT_W-1 -: 4] == 4'hF - $past(alnB[ALN_W-1 -: 4])); // R5
  AST_TZ_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rndMode == 3'd0 && !(signA ^ signB ^ opSub)) |=> corrA[7:0] == 8'h66); // R6
  AST_SPARE_SUB: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rndMode == 3'd7 && (signA ^ signB ^ opSub)) |=> corrA[7:0] == 8'h00); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(corrA) && $stable(corrB) && $stable(effSub))); // R9

endmodule

bind dec_inj_precorr dec_inj_precorr_chk #(.SIG_DIGITS(SIG_DIGITS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .signA    (signA),
  .signB    (signB),
  .opSub    (opSub),
  .rndMode  (rndMode),
  .alnB     (alnB),
  .corrA    (corrA),
  .corrB    (corrB),
  .effSub   (effSub),
  .outValid (outValid)
);

// File: tb/dec_inj_precorr_test.sv
module dec_inj_precorr_test;

  localparam int SIGD = 16;
  localparam int ALND = SIGD + 2;
  localparam int TOTD = SIGD + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signA = 1'b0, signB = 1'b0, opSub = 1'b0, resSign = 1'b0, stickyIn = 1'b0;
  logic [2:0] rndMode = 3'd0;
  logic [SIGD*4-1:0] sigA = '0;
  logic [ALND*4-1:0] alnB = '0;
  logic [TOTD*4-1:0] corrA, corrB;
  logic effSub, outValid;

  always #10 clk = ~clk; // 50 MHz

  dec_inj_precorr #(.SIG_DIGITS(SIGD)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .signA(signA), .signB(signB),
    .opSub(opSub), .rndMode(rndMode), .resSign(resSign), .sigA(sigA),
    .alnB(alnB), .stickyIn(stickyIn), .corrA(corrA), .corrB(corrB),
    .effSub(effSub), .outValid(outValid)
  );

  typedef struct {
    logic [TOTD*4-1:0] a;
    logic [TOTD*4-1:0] b;
    logic              e;
    string             tag;
  } item_t;

  item_t sbQueue[$];
  item_t lastItem;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic checkVal(input string tag, input logic [TOTD*4-1:0] act,
                          input logic [TOTD*4-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic item_t model(input bit sa, input bit sb, input bit op,
                                  input bit [2:0] m, input bit rs,
                                  input bit [SIGD*4-1:0] a, input bit [ALND*4-1:0] b,
                                  input bit st, input string tag);
    item_t it;
    bit [3:0] r, s;
    it.e = sa ^ sb ^ op;
    it.a = '0;
    it.b = '0;
    it.tag = tag;
    // R6 R7 R8 injection table
    case (m)
      3'd1, 3'd2: begin r = 4'd5; s = 4'd0; end
      3'd3:       begin r = 4'd4; s = 4'd9; end
      3'd4:       begin r = 4'd9; s = 4'd9; end
      3'd5:       begin r = rs ? 4'd0 : 4'd9; s = r; end
      3'd6:       begin r = rs ? 4'd9 : 4'd0; s = r; end
      default:    begin r = 4'd0; s = 4'd0; end
    endcase
    if (it.e) begin
      // R4, R5
      for (int i = 0; i < SIGD; i++) it.a[(i+3)*4 +: 4] = a[i*4 +: 4];
      it.a[7:4] = r;
      it.a[3:0] = s;
      for (int j = 0; j < ALND; j++) it.b[(j+1)*4 +: 4] = 4'd15 - b[j*4 +: 4];
      it.b[3:0] = 4'd15 - {3'b000, st};
    end else begin
      // R2, R3
      for (int i = 0; i < SIGD; i++) it.a[(i+2)*4 +: 4] = a[i*4 +: 4];
      it.a[7:4] = r;
      it.a[3:0] = s;
      for (int k = 0; k < TOTD; k++) it.a[k*4 +: 4] = it.a[k*4 +: 4] + 4'd6;
      for (int j = 1; j < ALND; j++) it.b[j*4 +: 4] = b[j*4 +: 4];
      it.b[3:0] = ((b[3:0] != 4'd0) || st) ? 4'd1 : 4'd0;
    end
    return it;
  endfunction

  task automatic drive(input bit sa, input bit sb, input bit op, input bit [2:0] m,
                       input bit rs, input bit [SIGD*4-1:0] a,
                       input bit [ALND*4-1:0] b, input bit st, input string tag);
    item_t it;
    @(negedge clk);
    signA = sa; signB = sb; opSub = op; rndMode = m; resSign = rs;
    sigA = a; alnB = b; stickyIn = st; inValid = 1'b1;
    it = model(sa, sb, op, m, rs, a, b, st, tag);
    sbQueue.push_back(it);
    lastItem = it;
  endtask

  // R9: idle cycles with toggling inputs leave the outputs unchanged
  task automatic idleHold;
    @(negedge clk);
    inValid = 1'b0;
    signA = ~signA; opSub = ~opSub; rndMode = rndMode + 3'd3; resSign = ~resSign;
    sigA = ~sigA; alnB = ~alnB; stickyIn = ~stickyIn;
    repeat (2) @(negedge clk);
    checkVal("R9 hold corrA", corrA, lastItem.a);
    checkVal("R9 hold corrB", corrB, lastItem.b);
    checkVal("R9 hold effSub", {75'b0, effSub}, {75'b0, lastItem.e});
    checkVal("R1 outValid low when idle", {75'b0, outValid}, '0);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQueue.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R1 unexpected outValid actual=1 expected=0");
      end else begin
        item_t it;
        it = sbQueue.pop_front();
        checkVal({it.tag, " R1 effSub"}, {75'b0, effSub}, {75'b0, it.e});
        checkVal({it.tag, " corrA"}, corrA, it.a);
        checkVal({it.tag, " corrB"}, corrB, it.b);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [SIGD*4-1:0] va;
    bit [ALND*4-1:0] vb;
    va = 64'h1234567890123456;
    vb = 72'h987654321098765430;
    repeat (3) @(negedge clk);
    // R9 reset state
    checkVal("R9 reset outValid", {75'b0, outValid}, '0);
    checkVal("R9 reset corrA", corrA, '0);
    checkVal("R9 reset corrB", corrB, '0);
    rstN = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R8 across all modes, both signs, both operations
    for (int m = 0; m < 8; m++) begin
      for (int rs = 0; rs < 2; rs++) begin
        drive(1'b0, 1'b0, 1'b0, 3'(m), rs[0], va, vb, 1'b0, "R2 R3 R6 R7 R8 add");
        drive(1'b0, 1'b1, 1'b0, 3'(m), rs[0], va, vb, 1'b1, "R4 R5 R6 R7 R8 sub");
      end
    end
    // R1: other sign/op combinations
    drive(1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 64'h9999999999999999, 72'h0, 1'b0, "R1 R2 neg+neg add");
    drive(1'b1, 1'b1, 1'b1, 3'd3, 1'b1, 64'h0, 72'h999999999999999999, 1'b0, "R1 R5 neg-neg sub");
    drive(1'b1, 1'b0, 1'b1, 3'd4, 1'b0, 64'h0000000000000001, 72'h000000000000000009, 1'b0, "R1 R3 eff add");
    // R3 sticky digit from low digit only, and from stickyIn only
    drive(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, va, 72'h000000000000000005, 1'b0, "R3 low digit sticky");
    drive(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, va, 72'h100000000000000000, 1'b1, "R3 stickyIn");
    idleHold();
    drive(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, va, vb, 1'b1, "R5 R7 sub down neg");
    idleHold();
    repeat (3) @(negedge clk);
    checkVal("R1 queue drained", {44'b0, 32'(sbQueue.size())}, '0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule